// File: doc/BRIEF.md
# Multi-Mode Audio Serial Port Transmitter

This block is the transmit half of a synchronous audio serial port. It turns parallel sample words into a serial stream on one data pin, MSB first, one bit per bit-clock period, and frames that stream with a frame sync pin. Three framing modes are offered. Normal mode puts one word in each frame. Network mode carries a programmable number of time slots (2 to 32) per frame. Gated-clock mode produces no frame sync at all, and the receiver relies only on the presence of bit clock pulses. The bit clock and frame sync are meant to be shared with an independent receive side.

Words reach the shifter through two channel queues. Each queue holds one word in a holding register, and behind it sits an optional 8-entry FIFO. In dual-channel operation the shifter takes its words alternately from channel 0 and channel 1. Writes use a valid/ready handshake: a word is taken on a clock edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` drops whenever the addressed queue cannot accept. The writer must then hold its word until ready returns. Configuration pins are sampled live, and they are to be changed only while `enable` is low. The intended order is to configure, raise `enable`, optionally preload words, and then raise `tx_en`.

The bit clock reaches the block as `bit_tick`, a one-cycle strobe in the system clock domain. Each strobe ends one bit period and starts the next. Strobes must be at least two system cycles apart. Mode codes are 0 for normal, 1 for network and 2 for gated. Code 3 behaves as normal.

Top module: `sap_tx`

## Requirements
- R1: Each word is sent MSB first as W = `word_len_m1`+1 bits (8 to 32), using the low W bits of the written word. Each bit appears on `txd` after the `bit_tick` edge that starts its bit period.
- R2: In normal mode every word is preceded by a single bit period in which `fs` is 1 and `txd` is 0. The data bit periods have `fs` at 0.
- R3: In network mode one frame-sync bit period is followed by `slots_m1`+1 words sent back to back (1 to 31 gives 2 to 32 slots), and then by the next frame sync.
- R4: In gated mode `fs` is never raised. The first strobe after start already carries the first word's MSB, and words follow one another with no gap.
- R5: With `dual_en` set, consecutive words are taken alternately from channel 0 and channel 1, starting with channel 0 each time transmission starts. With `dual_en` clear, only channel 0 is used.
- R6: With `fifo_en` set, each queue accepts words while its FIFO holds fewer than 8. The holding register refills from the FIFO without a gap, so words leave in write order. With `fifo_en` clear, a queue accepts only while its holding register is empty. `wr_ready` is 0 while `enable` is 0.
- R7: If the shifter starts a word and the selected holding register is empty, that word is sent as all zeros and `underrun` goes to 1. It stays at 1 until `enable` is cleared.
- R8: While `enable` or `tx_en` is 0, `txd` and `fs` are 0 from the next cycle on, whatever the strobes do. Clearing `enable` empties both queues and clears `underrun`.
- R9: `irq` is a one-cycle pulse in the cycle after a strobe that ends a word's last bit period, when `irq_word_en` is 1. It also pulses in the cycle after a queue's FIFO becomes empty by handing its last entry to the holding register, when `irq_empty_en` is 1.
- R10: `dma_req` is 1 while `enable` and `fifo_en` are 1 and the channel 0 FIFO level is at or below `watermark`. With `dual_en` set, the channel 1 FIFO level at or below `watermark` also raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Port enable; low flushes queues |
| tx_en | input | 1 | Start shifting (with enable) |
| mode | input | 2 | 0 normal, 1 network, 2 gated |
| slots_m1 | input | 5 | Network slots per frame minus one |
| word_len_m1 | input | 5 | Word length minus one (7..31) |
| dual_en | input | 1 | Alternate between channels 0 and 1 |
| fifo_en | input | 1 | Use the FIFOs behind the holding registers |
| irq_word_en | input | 1 | Interrupt after each word |
| irq_empty_en | input | 1 | Interrupt when a FIFO drains |
| watermark | input | 4 | FIFO low-watermark level |
| wr_valid | input | 1 | Write word valid |
| wr_chan | input | 1 | Write target channel |
| wr_data | input | 32 | Write word |
| wr_ready | output | 1 | Target queue can accept |
| bit_tick | input | 1 | Bit clock strobe, one cycle wide |
| txd | output | 1 | Serial transmit data |
| fs | output | 1 | Frame sync |
| irq | output | 1 | Transmit interrupt pulse |
| dma_req | output | 1 | Low-watermark request |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A corrupted slot or bit counter moves `fs` to the wrong strobe, and this shows within one frame: at most 32 word lengths plus one bit period. A wrong channel toggle shows as swapped words by the second word of a dual-channel run. A bad FIFO pointer or level shows as a word out of order at the next load, or as `wr_ready` and `dma_req` switching at the wrong fill count. A stuck holding-register valid shows as a false `underrun` or as a repeated word at the next strobe that starts a word.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_NETWORK = 2'd1,
    MODE_GATED   = 2'd2
  } sap_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_DATA = 2'd2
  } sap_phase_e;
endpackage

// File: rtl/sap_txq.sv
module sap_txq #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fifo_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  output logic          hold_valid,
  output logic [DW-1:0] hold_data,
  output logic [CW-1:0] level,
  output logic          drained
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          push, pop, fpush;

  assign in_ready = fifo_en ? (count < CW'(DEPTH)) : !hold_valid;
  assign push     = in_valid && in_ready && !flush;
  assign fpush    = push && fifo_en;
  assign pop      = !flush && fifo_en && (count != '0) && (!hold_valid || take);
  assign drained  = pop && (count == CW'(1)) && !fpush;
  assign level    = count;

  always_ff @(posedge clk) begin
    if (fpush) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      hold_valid <= 1'b0; hold_data <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
      hold_valid <= 1'b0;
    end else begin
      if (fpush) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)   rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(fpush) - CW'(pop);
      if (pop) begin
        hold_valid <= 1'b1;
        hold_data  <= mem[rp];
      end else if (push && !fifo_en) begin
        hold_valid <= 1'b1;
        hold_data  <= in_data;
      end else if (take) begin
        hold_valid <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && !take && !flush) |=> hold_valid); // R6
endmodule

// File: rtl/sap_framer.sv
module sap_framer
  import sap_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              bit_tick,
  input  logic [1:0]        mode,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic [LEN_W-1:0]  word_len_m1,
  input  logic              dual_en,
  output logic              load,
  output logic              load_ch,
  output logic              shift,
  output logic              clear,
  output logic              word_done,
  output logic              fs
);
  sap_phase_e        phase;
  logic [LEN_W-1:0]  bitc;
  logic [SLOT_W-1:0] slot;
  logic              ch;
  logic              gated, frame_last, at_end, go, to_sync;

  assign gated      = (sap_mode_e'(mode) == MODE_GATED);
  assign frame_last = (sap_mode_e'(mode) == MODE_NETWORK) ? (slot == slots_m1) : 1'b1;
  assign at_end     = (phase == PH_DATA) && (bitc == '0);
  assign go         = bit_tick && run;

  assign load = go && (((phase == PH_IDLE) && gated) || (phase == PH_SYNC) ||
                       (at_end && (gated || !frame_last)));
  assign to_sync = go && !gated &&
                   ((phase == PH_IDLE) || (at_end && frame_last));
  assign shift     = go && (phase == PH_DATA) && (bitc != '0);
  assign clear     = !run || to_sync;
  assign word_done = go && at_end;
  assign load_ch   = ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitc <= '0; slot <= '0; ch <= 1'b0; fs <= 1'b0;
    end else if (!run) begin
      phase <= PH_IDLE; bitc <= '0; slot <= '0; ch <= 1'b0; fs <= 1'b0;
    end else if (to_sync) begin
      phase <= PH_SYNC; fs <= 1'b1; slot <= '0;
    end else if (load) begin
      phase <= PH_DATA;
      fs    <= 1'b0;
      bitc  <= word_len_m1;
      ch    <= dual_en ? !ch : 1'b0;
      if (phase == PH_DATA) slot <= slot + 1'b1;
    end else if (shift) begin
      bitc <= bitc - 1'b1;
    end
  end

  AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && bit_tick) |=> !fs); // R2
  AST_GATED_NO_FS: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && bit_tick) |=> !fs); // R4
  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, shift, to_sync})); // R1
endmodule

// File: rtl/sap_shifter.sv
module sap_shifter #(
  parameter int DW    = 32,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             clear,
  input  logic [DW-1:0]    word,
  input  logic [LEN_W-1:0] word_len_m1,
  output logic             txd
);
  logic [DW-1:0] sh;
  logic [DW-1:0] aligned;

  assign aligned = word << (DW - 1 - int'(word_len_m1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; txd <= 1'b0;
    end else if (clear) begin
      sh <= '0; txd <= 1'b0;
    end else if (load) begin
      txd <= aligned[DW-1];
      sh  <= aligned << 1;
    end else if (shift) begin
      txd <= sh[DW-1];
      sh  <= sh << 1;
    end
  end
endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 5,
  parameter int LEN_W  = 5,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tx_en,
  input  logic [1:0]        mode,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic [LEN_W-1:0]  word_len_m1,
  input  logic              dual_en,
  input  logic              fifo_en,
  input  logic              irq_word_en,
  input  logic              irq_empty_en,
  input  logic [CW-1:0]     watermark,
  input  logic              wr_valid,
  input  logic              wr_chan,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_ready,
  input  logic              bit_tick,
  output logic              txd,
  output logic              fs,
  output logic              irq,
  output logic              dma_req,
  output logic              underrun
);
  localparam int NCH = 2;

  logic          run, load, load_ch, shift, clear, word_done;
  logic [NCH-1:0] q_ready, q_hold_v, q_drained;
  logic [DW-1:0] q_hold_d [NCH];
  logic [CW-1:0] q_level  [NCH];
  logic [DW-1:0] word;

  assign run = enable && tx_en;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sap_txq #(.DW(DW), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .flush(!enable), .fifo_en(fifo_en),
      .in_valid(wr_valid && enable && (wr_chan == 1'(c))),
      .in_data(wr_data), .in_ready(q_ready[c]),
      .take(load && (load_ch == 1'(c))),
      .hold_valid(q_hold_v[c]), .hold_data(q_hold_d[c]),
      .level(q_level[c]), .drained(q_drained[c])
    );
  end

  assign wr_ready = enable && q_ready[wr_chan];
  assign word     = q_hold_v[load_ch] ? q_hold_d[load_ch] : '0;
  assign dma_req  = enable && fifo_en &&
                    ((q_level[0] <= watermark) || (dual_en && (q_level[1] <= watermark)));

  sap_framer #(.SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick), .mode(mode),
    .slots_m1(slots_m1), .word_len_m1(word_len_m1), .dual_en(dual_en),
    .load(load), .load_ch(load_ch), .shift(shift), .clear(clear),
    .word_done(word_done), .fs(fs)
  );

  sap_shifter #(.DW(DW), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .clear(clear),
    .word(word), .word_len_m1(word_len_m1), .txd(txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (!enable)                         underrun <= 1'b0;
      else if (load && !q_hold_v[load_ch]) underrun <= 1'b1;
      irq <= (irq_word_en && word_done) || (irq_empty_en && (|q_drained));
    end
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && underrun) |=> underrun); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!fs && !txd)); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9
  AST_NO_READY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !wr_ready); // R6
endmodule

// File: tb/tb_sap_tx.sv
module tb_sap_tx;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        enable = 0, tx_en = 0, dual_en = 0, fifo_en = 0;
  logic        irq_word_en = 0, irq_empty_en = 0;
  logic [1:0]  mode = 2'd0;
  logic [4:0]  slots_m1 = 5'd0, word_len_m1 = 5'd7;
  logic [3:0]  watermark = 4'd0;
  logic        wr_valid = 0, wr_chan = 0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, bit_tick = 0, txd, fs, irq, dma_req, underrun;
  int n_chk = 0, n_fail = 0;

  sap_tx dut (.*);

  always #10 clk = !clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic grab(input int n, output logic [31:0] val, output bit fs_seen, output bit irq_first);
    val = '0; fs_seen = 0; irq_first = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      val = {val[30:0], txd};
      if (fs) fs_seen = 1;
      if (i == 0) irq_first = irq;
    end
  endtask

  task automatic wr(input logic ch, input logic [31:0] d, output bit rdy);
    @(negedge clk);
    rdy = wr_ready;
    wr_valid = 1'b1; wr_chan = ch; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic stop_all();
    @(negedge clk); tx_en = 0; enable = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(txd == 0 && fs == 0, "R8 reset outputs", {fs, txd}, 0);
    chk(irq == 0 && underrun == 0 && dma_req == 0, "R7 reset flags", {irq, underrun, dma_req}, 0);
    chk(wr_ready == 0, "R6 ready while disabled", wr_ready, 0);
  endtask

  task automatic t_normal();
    logic [31:0] v; bit fsn, irqf, r;
    mode = 2'd0; word_len_m1 = 5'd7; fifo_en = 0; dual_en = 0; irq_word_en = 1;
    @(negedge clk) enable = 1;
    wr(1'b0, 32'h1A5, r);
    chk(r, "R6 accepted", r, 1);
    @(negedge clk) tx_en = 1;
    tick();
    chk(fs == 1 && txd == 0, "R2 sync bit", {fs, txd}, 2'b10);
    grab(8, v, fsn, irqf);
    chk(v == 32'hA5, "R1 msb first low bits", v, 32'hA5);
    chk(!fsn, "R2 fs low in data", fsn, 0);
    tick();
    chk(fs == 1 && irq == 1, "R9 word irq and next sync", {fs, irq}, 2'b11);
    @(negedge clk);
    chk(irq == 0, "R9 irq one cycle", irq, 0);
    grab(9, v, fsn, irqf);
    chk(v == 0 && underrun == 1, "R7 underrun zeros", {underrun, v[7:0]}, 9'h100);
    @(negedge clk) enable = 0;
    @(negedge clk);
    chk(underrun == 0 && fs == 0 && txd == 0, "R8 disable clears", {underrun, fs, txd}, 0);
    tx_en = 0; irq_word_en = 0;
  endtask

  task automatic t_network();
    logic [31:0] v; bit fsn, irqf, r;
    mode = 2'd1; slots_m1 = 5'd2; word_len_m1 = 5'd7; fifo_en = 1;
    watermark = 4'd1; irq_empty_en = 1;
    @(negedge clk) enable = 1;
    wr(1'b0, 32'h11, r); wr(1'b0, 32'h22, r); wr(1'b0, 32'h33, r);
    @(negedge clk);
    chk(dma_req == 0, "R10 above watermark", dma_req, 0);
    tx_en = 1;
    tick();
    chk(fs == 1, "R3 frame sync", fs, 1);
    grab(8, v, fsn, irqf);
    chk(v == 32'h11 && !fsn, "R3 slot0", v, 32'h11);
    chk(dma_req == 1, "R10 at watermark", dma_req, 1);
    grab(8, v, fsn, irqf);
    chk(v == 32'h22 && !fsn, "R6 order slot1", v, 32'h22);
    chk(irqf == 1, "R9 drain irq", irqf, 1);
    grab(8, v, fsn, irqf);
    chk(v == 32'h33 && !fsn, "R3 slot2", v, 32'h33);
    tick();
    chk(fs == 1 && underrun == 0, "R3 next frame sync", {fs, underrun}, 2'b10);
    stop_all();
    irq_empty_en = 0;
  endtask

  task automatic t_gated_dual();
    logic [31:0] v; bit fsn, irqf, r;
    mode = 2'd2; word_len_m1 = 5'd11; fifo_en = 0; dual_en = 1;
    @(negedge clk) enable = 1;
    wr(1'b0, 32'hABC, r); wr(1'b1, 32'h123, r);
    @(negedge clk) tx_en = 1;
    grab(12, v, fsn, irqf);
    chk(v == 32'hABC, "R5 ch0 first", v, 32'hABC);
    chk(!fsn, "R4 no fs", fsn, 0);
    grab(12, v, fsn, irqf);
    chk(v == 32'h123 && !fsn, "R5 ch1 second R4", v, 32'h123);
    chk(underrun == 0, "R7 no underrun", underrun, 0);
    stop_all();
    dual_en = 0;
  endtask

  task automatic t_long();
    logic [31:0] v; bit fsn, irqf, r;
    mode = 2'd0; word_len_m1 = 5'd31;
    @(negedge clk) enable = 1;
    wr(1'b0, 32'h8000_0001, r);
    @(negedge clk) tx_en = 1;
    tick();
    grab(32, v, fsn, irqf);
    chk(v == 32'h8000_0001, "R1 32-bit word", v, 32'h8000_0001);
    stop_all();
  endtask

  task automatic t_backpressure();
    bit r;
    fifo_en = 1; tx_en = 0; watermark = 4'd0;
    @(negedge clk) enable = 1;
    for (int i = 0; i < 9; i++) begin
      wr(1'b0, 32'(i), r);
      chk(r, "R6 ready while room", r, 1);
    end
    @(negedge clk);
    chk(wr_ready == 0, "R6 full blocks", wr_ready, 0);
    chk(dma_req == 0, "R10 full no req", dma_req, 0);
    tick(); tick();
    chk(fs == 0 && txd == 0, "R8 quiet without tx_en", {fs, txd}, 0);
    stop_all();
    fifo_en = 0;
    @(negedge clk) enable = 1;
    wr(1'b1, 32'h5, r);
    @(negedge clk) wr_chan = 1'b1;
    #1 chk(wr_ready == 0, "R6 hold full no fifo", wr_ready, 0);
    stop_all();
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_network();
    t_gated_dual();
    t_long();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule